// File: doc/BRIEF.md
# Block-to-CHS Command Block Generator

This block turns a disk transfer request into a sequence of six-byte controller command blocks. A request carries a direction (read or write), a drive number, a starting logical block and a sector count. The block cuts the request into chunks, each no larger than a configured per-command sector limit. For every chunk it translates the starting logical block into cylinder, head and sector using the geometry of the chosen drive. It then streams the packed command bytes out over a valid/ready byte interface.

Per-drive geometry (sectors per track and head count) and a per-drive control byte arrive as flat configuration vectors, one slice per drive. Alongside each command the block shows the byte offset into the caller's buffer at which that chunk's data belongs. The divisions run on one shared multi-cycle restoring divider, so each chunk takes a few dozen cycles to prepare before its bytes appear. Running the commands and moving the data belong to other blocks.

Top module: `chs_cmd_gen`

## Requirements
- R1: After reset `req_ready` is 1 and `busy`, `done` and `cmd_valid` are 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. For a nonzero count, `busy` is 1 from the next cycle until the cycle in which `done` pulses, and `req_ready` is 0 throughout that time.
- R2: A request whose count is zero emits no command bytes. `done` is 1 in the cycle after acceptance and `busy` stays 0.
- R3: Each command covers min(remaining, max) sectors, where max is `cfg_max_sectors` and a max of 0 counts as 1. After each command the remaining count drops by that chunk size and the block number rises by it.
- R4: For a chunk starting at logical block B on drive d, with S sectors per track (`cfg_spt[d*6 +: 6]`) and H heads (`cfg_heads[d*5 +: 5]`), the block computes sector = B mod S, head = (B / S) mod H and cylinder = (B / S) / H.
- R5: Byte 0 is the opcode: `READ_OP` (default 8'h08) when `req_write` is 0 and `WRITE_OP` (default 8'h0A) when it is 1.
- R6: Byte 1 carries drive[2:0] in bits 7:5 and head[4:0] in bits 4:0.
- R7: Byte 2 carries cylinder[9:8] in bits 7:6 and sector[5:0] in bits 5:0. Byte 3 is cylinder[7:0]. Cylinder bits above bit 9 are dropped.
- R8: Byte 4 is the chunk sector count (low 8 bits). Byte 5 is the drive's control byte `cfg_ctrl[d*8 +: 8]`.
- R9: The bytes of a command go out in order 0 to 5. `cmd_last` is 1 exactly on byte 5. A byte presented with `cmd_ready` low is held, still valid and unchanged, until it is taken.
- R10: While a command's bytes are presented, `chunk_offset` equals 512 times the number of sectors covered by earlier commands of the same request, and it does not change.
- R11: Work on the next chunk starts only after byte 5 of the current command is taken, so `cmd_valid` is 0 in the cycle after that byte is taken. `done` pulses for one cycle in the cycle after the final byte of the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_drive | input | $clog2(DRIVES) | Drive number |
| req_block | input | BLK_W | Starting logical block |
| req_count | input | CNT_W | Sector count |
| cfg_max_sectors | input | CNT_W | Per-command sector limit (0 counts as 1) |
| cfg_spt | input | DRIVES*SPT_W | Sectors per track, one slice per drive |
| cfg_heads | input | DRIVES*HD_W | Head count, one slice per drive |
| cfg_ctrl | input | DRIVES*8 | Control byte, one slice per drive |
| cmd_valid | output | 1 | Command byte presented |
| cmd_ready | input | 1 | Consumer takes the byte |
| cmd_byte | output | 8 | Command byte |
| cmd_last | output | 1 | Byte 5 of the command |
| chunk_offset | output | CNT_W+9 | Buffer byte offset of the current chunk |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at request end |

## Verification
The bench uses the default parameters: eight drives, 21-bit block numbers and 8-bit counts, so the full 3-bit drive field and every sector and head width of the command layout are exercised. Geometries go down to one sector per track and one head. This makes cylinder numbers well above 1023 reachable and tests that the upper cylinder bits are dropped. A per-command limit of zero, counts that are exact multiples of the limit, and random consumer stalls cover the chunking and the byte-hold behaviour.

// File: rtl/chs_pkg.sv
package chs_pkg;

    // Six command bytes; index 0 is sent first.
    typedef logic [5:0][7:0] cmd_blk_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_TRK,
        ST_WAIT_TRK,
        ST_DIV_CYL,
        ST_WAIT_CYL,
        ST_LOAD,
        ST_SEND
    } gen_state_e;

    localparam int unsigned SECTOR_SHIFT = 9;

    function automatic cmd_blk_t pack_cmd(
        input logic [7:0] opcode,
        input logic [2:0] drv,
        input logic [4:0] head,
        input logic [9:0] cyl,
        input logic [5:0] sec,
        input logic [7:0] cnt,
        input logic [7:0] ctl
    );
        cmd_blk_t b;
        b[0] = opcode;
        b[1] = {drv, head};
        b[2] = {cyl[9:8], sec};
        b[3] = cyl[7:0];
        b[4] = cnt;
        b[5] = ctl;
        return b;
    endfunction

endpackage

// File: rtl/chs_divider.sv
module chs_divider #(
    parameter int N  = 21,
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [N-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [N-1:0]  quo,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(N + 1);

    logic          run_q, done_q;
    logic [CW-1:0] cnt_q;
    logic [N-1:0]  quo_q;
    logic [DW-1:0] rem_q, dvs_q;

    logic [DW:0]   shifted;
    logic [DW+1:0] diff;
    logic          fits;

    always_comb begin
        shifted = {rem_q, quo_q[N-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs_q};
        fits    = ~diff[DW+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= CW'(N);
                run_q <= 1'b1;
            end else if (run_q) begin
                quo_q <= {quo_q[N-2:0], fits};
                rem_q <= fits ? diff[DW-1:0] : shifted[DW-1:0];
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quo  = quo_q;
    assign rem  = rem_q;

    // R4: a finished division leaves a remainder below the divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (done_q && dvs_q != '0) |-> (rem_q < dvs_q));

endmodule

// File: rtl/chs_byte_sender.sv
module chs_byte_sender
    import chs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  cmd_blk_t blk_in,
    output logic     out_valid,
    input  logic     out_ready,
    output logic [7:0] out_byte,
    output logic     out_last,
    output logic     last_taken
);
    logic       active_q;
    logic [2:0] idx_q;
    cmd_blk_t   blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            blk_q    <= '0;
        end else if (load) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            blk_q    <= blk_in;
        end else if (active_q && out_ready) begin
            if (idx_q == 3'd5) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q <= idx_q + 3'd1;
            end
        end
    end

    assign out_valid  = active_q;
    assign out_byte   = blk_q[idx_q];
    assign out_last   = active_q && (idx_q == 3'd5);
    assign last_taken = out_last && out_ready;

    // R9: a stalled byte stays valid and unchanged
    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last)));

endmodule

// File: rtl/chs_cmd_gen.sv
module chs_cmd_gen
    import chs_pkg::*;
#(
    parameter int          DRIVES   = 8,
    parameter int          BLK_W    = 21,
    parameter int          CNT_W    = 8,
    parameter int          SPT_W    = 6,
    parameter int          HD_W     = 5,
    parameter logic [7:0]  READ_OP  = 8'h08,
    parameter logic [7:0]  WRITE_OP = 8'h0A
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [$clog2(DRIVES)-1:0]   req_drive,
    input  logic [BLK_W-1:0]            req_block,
    input  logic [CNT_W-1:0]            req_count,
    input  logic [CNT_W-1:0]            cfg_max_sectors,
    input  logic [DRIVES*SPT_W-1:0]     cfg_spt,
    input  logic [DRIVES*HD_W-1:0]      cfg_heads,
    input  logic [DRIVES*8-1:0]         cfg_ctrl,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic [7:0]                  cmd_byte,
    output logic                        cmd_last,
    output logic [CNT_W+SECTOR_SHIFT-1:0] chunk_offset,
    output logic                        busy,
    output logic                        done
);
    localparam int DRV_W = $clog2(DRIVES);
    localparam int DV_W  = (SPT_W > HD_W) ? SPT_W : HD_W;

    // Per-drive configuration slices
    logic [SPT_W-1:0] spt_arr  [DRIVES];
    logic [HD_W-1:0]  head_arr [DRIVES];
    logic [7:0]       ctl_arr  [DRIVES];

    for (genvar g = 0; g < DRIVES; g++) begin : g_cfg
        assign spt_arr[g]  = cfg_spt[g*SPT_W +: SPT_W];
        assign head_arr[g] = cfg_heads[g*HD_W +: HD_W];
        assign ctl_arr[g]  = cfg_ctrl[g*8 +: 8];
    end

    gen_state_e       state_q;
    logic             wr_q, done_q;
    logic [DRV_W-1:0] drv_q;
    logic [BLK_W-1:0] blk_q, track_q;
    logic [CNT_W-1:0] rem_q, chunk_q, sent_q;
    logic [DV_W-1:0]  sector_q;
    logic [HD_W-1:0]  head_q;
    logic [9:0]       cyl_q;

    logic [CNT_W-1:0] eff_max;
    logic             dv_start, dv_done;
    logic [BLK_W-1:0] dv_dividend, dv_quo;
    logic [DV_W-1:0]  dv_divisor, dv_rem;
    logic             pk_load, pk_taken;
    cmd_blk_t         pk_blk;

    assign eff_max = (cfg_max_sectors == '0) ? CNT_W'(1) : cfg_max_sectors;

    always_comb begin
        dv_start    = (state_q == ST_DIV_TRK) || (state_q == ST_DIV_CYL);
        dv_dividend = (state_q == ST_DIV_TRK) ? blk_q : track_q;
        dv_divisor  = (state_q == ST_DIV_TRK) ? DV_W'(spt_arr[drv_q])
                                              : DV_W'(head_arr[drv_q]);
        pk_load     = (state_q == ST_LOAD);
        pk_blk      = pack_cmd(wr_q ? WRITE_OP : READ_OP, 3'(drv_q), 5'(head_q),
                               cyl_q, 6'(sector_q), 8'(chunk_q), ctl_arr[drv_q]);
    end

    chs_divider #(.N(BLK_W), .DW(DV_W)) i_div (
        .clk      (clk),
        .rst      (rst),
        .start    (dv_start),
        .dividend (dv_dividend),
        .divisor  (dv_divisor),
        .done     (dv_done),
        .quo      (dv_quo),
        .rem      (dv_rem)
    );

    chs_byte_sender i_send (
        .clk        (clk),
        .rst        (rst),
        .load       (pk_load),
        .blk_in     (pk_blk),
        .out_valid  (cmd_valid),
        .out_ready  (cmd_ready),
        .out_byte   (cmd_byte),
        .out_last   (cmd_last),
        .last_taken (pk_taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wr_q     <= 1'b0;
            done_q   <= 1'b0;
            drv_q    <= '0;
            blk_q    <= '0;
            track_q  <= '0;
            rem_q    <= '0;
            chunk_q  <= '0;
            sent_q   <= '0;
            sector_q <= '0;
            head_q   <= '0;
            cyl_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    wr_q   <= req_write;
                    drv_q  <= req_drive;
                    blk_q  <= req_block;
                    rem_q  <= req_count;
                    sent_q <= '0;
                    if (req_count == '0) done_q  <= 1'b1;
                    else                 state_q <= ST_DIV_TRK;
                end
                ST_DIV_TRK: begin
                    chunk_q <= (rem_q < eff_max) ? rem_q : eff_max;
                    state_q <= ST_WAIT_TRK;
                end
                ST_WAIT_TRK: if (dv_done) begin
                    track_q  <= dv_quo;
                    sector_q <= dv_rem;
                    state_q  <= ST_DIV_CYL;
                end
                ST_DIV_CYL: state_q <= ST_WAIT_CYL;
                ST_WAIT_CYL: if (dv_done) begin
                    head_q  <= dv_rem[HD_W-1:0];
                    cyl_q   <= dv_quo[9:0];
                    state_q <= ST_LOAD;
                end
                ST_LOAD: state_q <= ST_SEND;
                ST_SEND: if (pk_taken) begin
                    rem_q  <= rem_q - chunk_q;
                    blk_q  <= blk_q + BLK_W'(chunk_q);
                    sent_q <= sent_q + chunk_q;
                    if (rem_q == chunk_q) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= ST_DIV_TRK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (state_q == ST_IDLE);
    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign chunk_offset = {sent_q, {SECTOR_SHIFT{1'b0}}};

    // R11: the done pulse only appears once the block is idle again
    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3: a chunk on the wire is nonzero and fits in what remains
    a_r3_chunk_bounds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEND) |-> (chunk_q != '0 && chunk_q <= rem_q && chunk_q <= eff_max));

    // R2: an empty request finishes at once and sends nothing
    a_r2_empty_request: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_count == '0) |=> (done && !cmd_valid && !busy));

    // R10: buffer offset is frozen while a command is still being sent
    a_r10_offset_frozen: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !(cmd_ready && cmd_last)) |=> $stable(chunk_offset));

    // R9: command bytes only appear while a request is active
    a_r9_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);

endmodule

// File: tb/test_chs_cmd_gen.sv
module test_chs_cmd_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DRIVES = 8;
    localparam int BLK_W  = 21;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_drive = '0;
    logic [BLK_W-1:0] req_block = '0;
    logic [CNT_W-1:0] req_count = '0, cfg_max_sectors = '0;
    logic [DRIVES*6-1:0] cfg_spt = '0;
    logic [DRIVES*5-1:0] cfg_heads = '0;
    logic [DRIVES*8-1:0] cfg_ctrl = '0;
    logic cmd_ready = 1'b0;
    logic req_ready, cmd_valid, cmd_last, busy, done;
    logic [7:0] cmd_byte;
    logic [CNT_W+8:0] chunk_offset;

    int checks = 0;
    int fails  = 0;
    int rdy_pct = 100;
    int g_spt [DRIVES];
    int g_hd  [DRIVES];
    int g_ctl [DRIVES];

    always #(CLK_PERIOD/2) clk = ~clk;

    chs_cmd_gen i_chs_cmd_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_drive(req_drive), .req_block(req_block),
        .req_count(req_count), .cfg_max_sectors(cfg_max_sectors),
        .cfg_spt(cfg_spt), .cfg_heads(cfg_heads), .cfg_ctrl(cfg_ctrl),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
        .cmd_last(cmd_last), .chunk_offset(chunk_offset), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_geom(input int d, input int spt, input int hd, input int ctl);
        g_spt[d] = spt; g_hd[d] = hd; g_ctl[d] = ctl;
        cfg_spt[d*6 +: 6]   = 6'(spt);
        cfg_heads[d*5 +: 5] = 5'(hd);
        cfg_ctrl[d*8 +: 8]  = 8'(ctl);
    endtask

    function automatic logic [7:0] exp_byte(input int k, input bit wr, input int drv,
                                            input int blk, input int chunk);
        int trk, sec, head, cyl;
        trk  = blk / g_spt[drv];
        sec  = blk % g_spt[drv];
        head = trk % g_hd[drv];
        cyl  = trk / g_hd[drv];
        case (k)
            0: return wr ? 8'h0A : 8'h08;
            1: return {drv[2:0], head[4:0]};
            2: return {cyl[9:8], sec[5:0]};
            3: return cyl[7:0];
            4: return chunk[7:0];
            default: return g_ctl[drv][7:0];
        endcase
    endfunction

    function automatic string req_of(input int k);
        case (k)
            0: return "R5";
            1: return "R6";
            2, 3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run_req(input bit wr, input int drv, input int blk,
                           input int cnt, input int maxs);
        int erem, eblk, esent, idx, chunk, emax;
        bit just_fin;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_drive = 3'(drv);
        req_block = BLK_W'(blk); req_count = CNT_W'(cnt); cfg_max_sectors = CNT_W'(maxs);
        @(negedge clk);
        req_valid = 1'b0;
        if (cnt == 0) begin
            chk(done === 1'b1 && busy === 1'b0 && cmd_valid === 1'b0, "R2",
                int'({done, busy, cmd_valid}), 3'b100);
            @(negedge clk);
            chk(done === 1'b0 && cmd_valid === 1'b0, "R2", int'({done, cmd_valid}), 0);
            return;
        end
        chk(busy === 1'b1 && done === 1'b0 && req_ready === 1'b0, "R1",
            int'({busy, done, req_ready}), 3'b100);
        emax = (maxs == 0) ? 1 : maxs;
        erem = cnt; eblk = blk; esent = 0; idx = 0; just_fin = 1'b0;
        forever begin
            if (done === 1'b1) break;
            if (just_fin) chk(cmd_valid === 1'b0, "R11", int'(cmd_valid), 0);
            just_fin = 1'b0;
            if (erem == 0) chk(1'b0, "R11", int'(done), 1);
            chunk = (erem < emax) ? erem : emax;
            if (cmd_valid === 1'b1) begin
                chk(cmd_byte === exp_byte(idx, wr, drv, eblk, chunk), req_of(idx),
                    int'(cmd_byte), int'(exp_byte(idx, wr, drv, eblk, chunk)));
                chk(cmd_last === (idx == 5), "R9", int'(cmd_last), int'(idx == 5));
                chk(int'(chunk_offset) == esent * 512, "R10", int'(chunk_offset), esent * 512);
                chk(busy === 1'b1, "R1", int'(busy), 1);
            end
            cmd_ready = (($urandom % 100) < rdy_pct);
            if (cmd_valid === 1'b1 && cmd_ready) begin
                idx++;
                if (idx == 6) begin
                    idx = 0; erem -= chunk; eblk += chunk; esent += chunk; just_fin = 1'b1;
                end
            end
            @(negedge clk);
        end
        chk(erem == 0 && idx == 0 && busy === 1'b0, "R3", erem, 0);
        @(negedge clk);
        chk(done === 1'b0, "R11", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int d = 0; d < DRIVES; d++) set_geom(d, 17, 4, 8'h10 + d);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(req_ready === 1'b1 && busy === 1'b0 && done === 1'b0 && cmd_valid === 1'b0,
            "R1", int'({req_ready, busy, done, cmd_valid}), 4'b1000);

        // R2: empty request
        run_req(1'b0, 1, 100, 0, 4);
        // R3: limit of zero counts as one
        run_req(1'b1, 0, 33, 3, 0);
        // R3: count is an exact multiple of the limit, crossing a track
        run_req(1'b0, 3, 15, 8, 4);
        // R7: cylinder beyond 1023 with tiny geometry
        set_geom(2, 1, 1, 8'hA5);
        run_req(1'b1, 2, 1500, 2, 4);
        // R4/R7: largest geometry near the top of the block range
        set_geom(7, 63, 31, 8'h3C);
        run_req(1'b0, 7, 2097000, 5, 2);
        // R9: heavy stalls
        rdy_pct = 30;
        run_req(1'b1, 5, 4097, 6, 3);

        for (int n = 0; n < 25; n++) begin
            int d;
            d = $urandom % DRIVES;
            set_geom(d, 1 + $urandom % 63, 1 + $urandom % 31, $urandom % 256);
            rdy_pct = 40 + $urandom % 61;
            run_req(1'($urandom % 2), d, $urandom % ((1 << BLK_W) - 64),
                    1 + $urandom % 20, ($urandom % 8 == 0) ? 0 : 1 + $urandom % 16);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule